// File: doc/BRIEF.md
# Command Response Checker

After a host issues a command frame to a peripheral over a byte-serial link, the peripheral clocks a response back. This block consumes that returned byte stream, one byte per valid strobe, and decides whether the command succeeded. It checks that the peripheral echoed the issued opcode and returned a clean status byte. For reads it then searches for the data-start marker and captures the returned register word. When the last byte it needs has arrived, it raises a single-cycle done pulse together with a result code.

The host pulses `start` with the opcode it sent and whether frame CRC is in use, then streams the received bytes in. Control opcodes (reset, terminate, repeat) return one extra leading byte, which the checker drops before it looks for the echo. If the data marker never shows up within a bounded number of bytes, the outcome is a needs-reset code, so the host knows to resynchronise the link rather than just retry.

Top module: `cmd_resp_checker`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 (none) and `readWord` is 0.
- R2: A `start` pulse latches `opcode` and `crcEn`, and in the next cycle `result` reads 0 and `readWord` reads 0. A byte presented in the same cycle as `start` is ignored. A `start` during a command abandons it and begins the new one.
- R3: For control opcodes 0xCF, 0xC5 and 0xC6, the first received byte is discarded and the second is treated as the echo.
- R4: If the echo byte differs from the latched opcode, the command ends with result 2 (fail).
- R5: If the byte after the echo is not 0x00, the command ends with result 2 (fail).
- R6: For every opcode that is neither control nor read-type, and for control opcodes, a 0x00 status byte ends the command with result 1 (ok).
- R7: For the read-type opcodes 0xC2, 0xC4, 0xC8 and 0xCA, bytes after the status are discarded until one arrives whose bits [7:4] equal 0xF. That byte is the data header.
- R8: If none of the first HDR_LIMIT bytes after the status (default 100) is a header, the command ends on the HDR_LIMIT-th byte with result 3 (needs-reset). A header arriving as that byte is still accepted.
- R9: For 0xC4 and 0xCA, the four bytes after the header are captured least significant byte first into `readWord`. With `crcEn` low, the command ends with result 1 on the fourth data byte.
- R10: For 0xC4 and 0xCA with `crcEn` high, two further bytes after the data are consumed without checking their value, and the command ends with result 1 on the second of them.
- R11: For 0xC2 and 0xC8, the command ends with result 1 on the header byte itself.
- R12: `done` is high for exactly one cycle, in the cycle after the clock edge that takes the final byte. `result` keeps its value from then until the next `start`.
- R13: While `rxValid` is low, or while no command is in progress, `rxByte` has no effect on `done`, `result` or `readWord`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin checking the response to a new command |
| opcode | input | 8 | Opcode of the issued command, sampled on `start` |
| crcEn | input | 1 | Frame CRC in use, sampled on `start` |
| rxValid | input | 1 | `rxByte` holds a received byte this cycle |
| rxByte | input | 8 | Received response byte |
| done | output | 1 | One-cycle pulse when the command's outcome is known |
| result | output | 2 | 0 none, 1 ok, 2 fail, 3 needs-reset |
| readWord | output | 32 | Word captured by a short read |

## Verification
The hardest case to reach is the edge of the header search window. The outcome flips between needs-reset and success depending on whether the marker arrives as the limit-th byte or never arrives at all. The stimulus streams exactly one short of the limit in filler bytes whose upper nibble is not 0xF. It then sends either one more filler byte or a marker byte, and checks that no pulse appears early. Separately, the overlap of `start` with a valid byte is driven in the same cycle to show that the byte does not shift the echo position.

// File: rtl/rsp_chk_pkg.sv
package rsp_chk_pkg;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_OK    = 2'd1,
    RES_FAIL  = 2'd2,
    RES_RESET = 2'd3
  } result_e;

  typedef enum logic [1:0] {
    CLS_WRITE,
    CLS_CTRL,
    CLS_LONG_RD,
    CLS_SHORT_RD
  } cmd_class_e;

  localparam logic [7:0] OP_BLOCK_RD = 8'hC2;
  localparam logic [7:0] OP_LOCAL_RD = 8'hC4;
  localparam logic [7:0] OP_END      = 8'hC5;
  localparam logic [7:0] OP_AGAIN    = 8'hC6;
  localparam logic [7:0] OP_XBLK_RD  = 8'hC8;
  localparam logic [7:0] OP_WORD_RD  = 8'hCA;
  localparam logic [7:0] OP_SOFT_RST = 8'hCF;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
    logic setOk;
    logic setFail;
    logic setReset;
  } dp_ctrl_t;

  function automatic cmd_class_e classify(input logic [7:0] op);
    cmd_class_e cls;
    case (op)
      OP_SOFT_RST, OP_END, OP_AGAIN: cls = CLS_CTRL;
      OP_BLOCK_RD, OP_XBLK_RD:       cls = CLS_LONG_RD;
      OP_LOCAL_RD, OP_WORD_RD:       cls = CLS_SHORT_RD;
      default:                       cls = CLS_WRITE;
    endcase
    return cls;
  endfunction

endpackage

// File: rtl/rsp_datapath.sv
module rsp_datapath
  import rsp_chk_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter logic [3:0] HDR_NIBBLE = 4'hF,
  localparam int WORD_W = DATA_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic [7:0]        opcodeIn,
  input  logic              crcEnIn,
  input  logic [7:0]        rxByte,
  output cmd_class_e        cmdClass,
  output logic              crcOn,
  output logic              echoOk,
  output logic              statusOk,
  output logic              hdrHit,
  output logic [WORD_W-1:0] readWord,
  output logic [1:0]        result
);

  logic [7:0] opReg;
  logic       crcReg;
  result_e    resQ;
  logic [7:0] lane [DATA_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg  <= '0;
      crcReg <= 1'b0;
    end else if (ctl.load) begin
      opReg  <= opcodeIn;
      crcReg <= crcEnIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             resQ <= RES_NONE;
    else if (ctl.clear)    resQ <= RES_NONE;
    else if (ctl.setReset) resQ <= RES_RESET;
    else if (ctl.setFail)  resQ <= RES_FAIL;
    else if (ctl.setOk)    resQ <= RES_OK;
  end

  // Byte lanes: new bytes enter at the top and move down, so the first byte lands in lane 0
  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    if (i == DATA_BYTES - 1) begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          lane[i] <= '0;
        else if (ctl.clear) lane[i] <= '0;
        else if (ctl.shift) lane[i] <= rxByte;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          lane[i] <= '0;
        else if (ctl.clear) lane[i] <= '0;
        else if (ctl.shift) lane[i] <= lane[i+1];
      end
    end
    assign readWord[i*8 +: 8] = lane[i];
  end

  assign cmdClass = classify(opReg);
  assign crcOn    = crcReg;
  assign echoOk   = (rxByte == opReg);
  assign statusOk = (rxByte == 8'h00);
  assign hdrHit   = (rxByte[7:4] == HDR_NIBBLE);
  assign result   = resQ;

endmodule

// File: rtl/rsp_control.sv
module rsp_control
  import rsp_chk_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int CRC_BYTES  = 2,
  parameter int HDR_LIMIT  = 100,
  localparam int HUNT_W = $clog2(HDR_LIMIT + 1),
  localparam int CNT_W  = $clog2(DATA_BYTES + CRC_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opcodeIn,
  input  logic       rxValid,
  input  cmd_class_e cmdClass,
  input  logic       crcOn,
  input  logic       echoOk,
  input  logic       statusOk,
  input  logic       hdrHit,
  output dp_ctrl_t   ctl,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SKIP, ST_ECHO, ST_STAT, ST_HUNT, ST_DATA, ST_CRC
  } state_e;

  state_e            state, stateNext;
  logic [HUNT_W-1:0] huntCnt, huntNext;
  logic [CNT_W-1:0]  byteCnt, byteNext;

  always_comb begin
    stateNext = state;
    huntNext  = huntCnt;
    byteNext  = byteCnt;
    ctl       = '0;
    if (start) begin
      ctl.clear = 1'b1;
      ctl.load  = 1'b1;
      stateNext = (classify(opcodeIn) == CLS_CTRL) ? ST_SKIP : ST_ECHO;
    end else if (rxValid) begin
      case (state)
        ST_SKIP: stateNext = ST_ECHO;
        ST_ECHO: begin
          if (echoOk) stateNext = ST_STAT;
          else begin
            ctl.setFail = 1'b1;
            stateNext   = ST_IDLE;
          end
        end
        ST_STAT: begin
          if (!statusOk) begin
            ctl.setFail = 1'b1;
            stateNext   = ST_IDLE;
          end else if (cmdClass == CLS_LONG_RD || cmdClass == CLS_SHORT_RD) begin
            huntNext  = '0;
            stateNext = ST_HUNT;
          end else begin
            ctl.setOk = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        ST_HUNT: begin
          huntNext = huntCnt + 1'b1;
          if (hdrHit) begin
            if (cmdClass == CLS_SHORT_RD) begin
              byteNext  = '0;
              stateNext = ST_DATA;
            end else begin
              ctl.setOk = 1'b1;
              stateNext = ST_IDLE;
            end
          end else if (huntCnt == HUNT_W'(HDR_LIMIT - 1)) begin
            ctl.setReset = 1'b1;
            stateNext    = ST_IDLE;
          end
        end
        ST_DATA: begin
          ctl.shift = 1'b1;
          if (byteCnt == CNT_W'(DATA_BYTES - 1)) begin
            byteNext = '0;
            if (crcOn) stateNext = ST_CRC;
            else begin
              ctl.setOk = 1'b1;
              stateNext = ST_IDLE;
            end
          end else begin
            byteNext = byteCnt + 1'b1;
          end
        end
        ST_CRC: begin
          if (byteCnt == CNT_W'(CRC_BYTES - 1)) begin
            ctl.setOk = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            byteNext = byteCnt + 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      huntCnt <= '0;
      byteCnt <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      huntCnt <= huntNext;
      byteCnt <= byteNext;
      done    <= ctl.setOk | ctl.setFail | ctl.setReset;
    end
  end

endmodule

// File: rtl/cmd_resp_checker.sv
module cmd_resp_checker
  import rsp_chk_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int CRC_BYTES  = 2,
  parameter int HDR_LIMIT  = 100,
  parameter logic [3:0] HDR_NIBBLE = 4'hF,
  localparam int WORD_W = DATA_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              crcEn,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              done,
  output logic [1:0]        result,
  output logic [WORD_W-1:0] readWord
);

  dp_ctrl_t   ctl;
  cmd_class_e cmdClass;
  logic       crcOn, echoOk, statusOk, hdrHit;

  rsp_control #(
    .DATA_BYTES(DATA_BYTES), .CRC_BYTES(CRC_BYTES), .HDR_LIMIT(HDR_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcodeIn(opcode), .rxValid(rxValid),
    .cmdClass(cmdClass), .crcOn(crcOn), .echoOk(echoOk), .statusOk(statusOk),
    .hdrHit(hdrHit), .ctl(ctl), .done(done)
  );

  rsp_datapath #(
    .DATA_BYTES(DATA_BYTES), .HDR_NIBBLE(HDR_NIBBLE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opcodeIn(opcode), .crcEnIn(crcEn),
    .rxByte(rxByte), .cmdClass(cmdClass), .crcOn(crcOn), .echoOk(echoOk),
    .statusOk(statusOk), .hdrHit(hdrHit), .readWord(readWord), .result(result)
  );

endmodule

// File: rtl/cmd_resp_checker_sva.sv
module cmd_resp_checker_sva #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rxValid,
  input logic              done,
  input logic [1:0]        result,
  input logic [WORD_W-1:0] readWord
);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result != 2'd0));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (result == 2'd0 && !done && readWord == '0));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(result) || done));

  // R13
  word_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !rxValid) |=> $stable(readWord));

endmodule

bind cmd_resp_checker cmd_resp_checker_sva #(.WORD_W(DATA_BYTES * 8)) u_sva (
  .clk(clk), .rstN(rstN), .start(start), .rxValid(rxValid),
  .done(done), .result(result), .readWord(readWord)
);

// File: tb/tb_cmd_resp_checker.sv
module tb_cmd_resp_checker;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        crcEn = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        done;
  logic [1:0]  result;
  logic [31:0] readWord;

  int checks = 0;
  int errors = 0;

  cmd_resp_checker #(.HDR_LIMIT(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .crcEn(crcEn),
    .rxValid(rxValid), .rxByte(rxByte), .done(done), .result(result),
    .readWord(readWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic issue(input logic [7:0] op, input logic crc);
    start = 1'b1; opcode = op; crcEn = crc;
    @(negedge clk);
    start = 1'b0;
    check(result == 2'd0 && !done, "R2 clear", {30'd0, result}, 32'd0);
  endtask

  task automatic feed(input logic [7:0] b, input bit expDone, input logic [1:0] expRes,
                      input string req);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
    check(done == expDone, req, {31'd0, done}, {31'd0, expDone});
    if (expDone) check(result == expRes, req, {30'd0, result}, {30'd0, expRes});
  endtask

  task automatic t_reset();
    check(done == 1'b0 && result == 2'd0, "R1 outputs", {30'd0, result}, 32'd0);
    check(readWord == 32'd0, "R1 word", readWord, 32'd0);
  endtask

  task automatic t_write();
    issue(8'hC9, 1'b0);
    feed(8'hC9, 0, 2'd0, "R6 echo");
    feed(8'h00, 1, 2'd1, "R6 write ok");
    issue(8'hC3, 1'b1);
    feed(8'hC3, 0, 2'd0, "R6 echo");
    feed(8'h00, 1, 2'd1, "R6 local write ok");
  endtask

  task automatic t_control();
    issue(8'hC5, 1'b0);
    feed(8'h55, 0, 2'd0, "R3 skip");
    feed(8'hC5, 0, 2'd0, "R3 echo");
    feed(8'h00, 1, 2'd1, "R3 control ok");
    issue(8'hCF, 1'b0);
    feed(8'hCF, 0, 2'd0, "R3 skip consumes echo");
    feed(8'h00, 1, 2'd2, "R3 late echo fails");
  endtask

  task automatic t_bad();
    issue(8'hCA, 1'b0);
    feed(8'hCB, 1, 2'd2, "R4 echo mismatch");
    issue(8'hCA, 1'b0);
    feed(8'hCA, 0, 2'd0, "R5 echo");
    feed(8'h01, 1, 2'd2, "R5 bad status");
  endtask

  task automatic t_short_read();
    issue(8'hCA, 1'b0);
    feed(8'hCA, 0, 2'd0, "R7 echo");
    feed(8'h00, 0, 2'd0, "R7 status");
    feed(8'h00, 0, 2'd0, "R7 filler");
    feed(8'h3E, 0, 2'd0, "R7 filler");
    feed(8'hF1, 0, 2'd0, "R7 header");
    feed(8'h11, 0, 2'd0, "R9 d0");
    // R13: byte without valid must not enter the word
    rxByte = 8'h99;
    @(negedge clk);
    check(!done, "R13 no valid", {31'd0, done}, 32'd0);
    feed(8'h22, 0, 2'd0, "R9 d1");
    feed(8'h33, 0, 2'd0, "R9 d2");
    feed(8'h44, 1, 2'd1, "R9 ok");
    check(readWord == 32'h44332211, "R9 word", readWord, 32'h44332211);
  endtask

  task automatic t_crc_read();
    issue(8'hC4, 1'b1);
    feed(8'hC4, 0, 2'd0, "R10 echo");
    feed(8'h00, 0, 2'd0, "R10 status");
    feed(8'hF3, 0, 2'd0, "R10 header");
    feed(8'hAA, 0, 2'd0, "R10 d0");
    feed(8'hBB, 0, 2'd0, "R10 d1");
    feed(8'hCC, 0, 2'd0, "R10 d2");
    feed(8'hDD, 0, 2'd0, "R10 no end before crc");
    feed(8'hF2, 0, 2'd0, "R10 crc0");
    feed(8'h34, 1, 2'd1, "R10 ok");
    check(readWord == 32'hDDCCBBAA, "R10 word", readWord, 32'hDDCCBBAA);
  endtask

  task automatic t_long_read();
    issue(8'hC8, 1'b0);
    feed(8'hC8, 0, 2'd0, "R11 echo");
    feed(8'h00, 0, 2'd0, "R11 status");
    feed(8'h2F, 0, 2'd0, "R11 filler");
    feed(8'hFF, 1, 2'd1, "R11 header ok");
  endtask

  task automatic t_timeout();
    issue(8'hCA, 1'b0);
    feed(8'hCA, 0, 2'd0, "R8 echo");
    feed(8'h00, 0, 2'd0, "R8 status");
    for (int i = 0; i < LIMIT - 1; i++) feed(8'hE0, 0, 2'd0, "R8 search");
    feed(8'hE0, 1, 2'd3, "R8 needs reset");
    issue(8'hC2, 1'b0);
    feed(8'hC2, 0, 2'd0, "R8 echo");
    feed(8'h00, 0, 2'd0, "R8 status");
    for (int i = 0; i < LIMIT - 1; i++) feed(8'h0F, 0, 2'd0, "R8 search");
    feed(8'hF0, 1, 2'd1, "R8 header at limit");
  endtask

  task automatic t_idle_hold();
    logic [31:0] w;
    issue(8'hCA, 1'b0);
    feed(8'hCA, 0, 2'd0, "R12 echo");
    feed(8'h00, 0, 2'd0, "R12 status");
    feed(8'hF0, 0, 2'd0, "R12 header");
    feed(8'h01, 0, 2'd0, "R12 d0");
    feed(8'h02, 0, 2'd0, "R12 d1");
    feed(8'h03, 0, 2'd0, "R12 d2");
    feed(8'h04, 1, 2'd1, "R12 ok");
    w = readWord;
    @(negedge clk);
    check(!done, "R12 single pulse", {31'd0, done}, 32'd0);
    feed(8'hF5, 0, 2'd0, "R13 idle byte");
    feed(8'h00, 0, 2'd0, "R13 idle byte");
    check(result == 2'd1, "R12 hold result", {30'd0, result}, 32'd1);
    check(readWord == w, "R13 word kept", readWord, w);
  endtask

  task automatic t_restart();
    issue(8'hCA, 1'b0);
    feed(8'hCA, 0, 2'd0, "R2 first");
    feed(8'h00, 0, 2'd0, "R2 first status");
    // start with a valid byte in the same cycle: byte ignored
    start = 1'b1; opcode = 8'hC9; crcEn = 1'b0; rxValid = 1'b1; rxByte = 8'hC9;
    @(negedge clk);
    start = 1'b0; rxValid = 1'b0;
    check(result == 2'd0 && !done, "R2 restart clear", {30'd0, result}, 32'd0);
    feed(8'hC9, 0, 2'd0, "R2 echo after restart");
    feed(8'h00, 1, 2'd1, "R2 restart ok");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_control();
    t_bad();
    t_short_read();
    t_crc_read();
    t_long_read();
    t_timeout();
    t_idle_hold();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule